// File: doc/BRIEF.md
# Gated-FIFO Asynchronous Serial Receiver

This block receives asynchronous serial characters from a single input line. It oversamples the line with a baud-rate tick that runs at a fixed multiple of the bit rate. A falling edge only counts as a start bit if the line is still low at mid-bit, so short glitches are dropped. The block then shifts in 7 or 8 data bits, least significant bit first, reads an optional parity bit, and samples the stop bit.

Every finished character updates the status flags, whether or not it is stored. The character is written into a 16-entry receive queue only if all of these hold: the queue has room, no overrun is pending, no break is pending, and the character is not itself a break. Parity and framing errors are recorded but do not stop a character from being stored.

Three level interrupt requests come from the flags:
- a receive-data request, for queue fill or a queue that has gone quiet;
- a receive-error request, for parity or framing faults;
- a break/overrun request.

Software empties the queue through a show-ahead read port and clears the sticky flags with one-cycle strobes.

Top module: `serial_rx_gated`

## Requirements
- R1: A low line seen on a baud tick while idle starts a character only if the line is still low at the mid-point of the start bit (OSR/2 ticks later). A low pulse shorter than that returns the receiver to idle, and no character is produced.
- R2: Data bits are assembled least significant bit first. With `cfg_len8`=1 there are 8 data bits. With `cfg_len8`=0 there are 7, and `rd_data[7]` reads 0.
- R3: `cfg_par` selects the parity mode: 00 none, 01 even, 10 odd, 11 none. A parity bit that does not match the mode sets `sts_per`, and the character is still stored.
- R4: A character that completes while the queue holds DEPTH entries sets `sts_ovr` and leaves the queue unchanged. `sts_ovr` stays set until `clr_ovr`, and while it is set no character is stored.
- R5: A 0 in the first stop bit sets `sts_fer`, the character is still stored, and the receiver waits for the line to return high. With `cfg_stop2`=1 the second stop bit is neither checked nor taken as a start bit.
- R6: A frame whose data, parity (if enabled) and first stop bit are all 0 sets `sts_brk` and `sts_fer` and is not stored. `sts_brk` stays set until `clr_brk`, and while it is set no character is stored.
- R7: The queue holds up to DEPTH characters in arrival order. `rd_data` shows the oldest entry while `rd_valid` is 1, `rd_en` removes it, and `fill_cnt` gives the number of entries.
- R8: `sts_rdf` is 1 exactly when `fill_cnt` is at least `cfg_thresh` (1 to DEPTH).
- R9: `sts_dr` rises when the queue is non-empty and below threshold and the receiver has stayed idle for DR_BITS×OSR baud ticks since the last write or read. `irq_rxd` equals `en_rie` AND (`sts_rdf` OR `sts_dr`).
- R10: `irq_err` equals (`en_rie` OR `en_reie`) AND (`sts_fer` OR `sts_per`). `clr_err` clears both error flags.
- R11: `irq_bov` equals (`en_rie` OR `en_reie`) AND (`sts_ovr` OR `sts_brk`).
- R12: After reset the queue is empty, and every flag and interrupt output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-cycle pulse at OSR times the bit rate |
| rxd | input | 1 | Serial receive line, idle high |
| cfg_len8 | input | 1 | 1: 8 data bits, 0: 7 data bits |
| cfg_par | input | 2 | Parity mode (00/11 none, 01 even, 10 odd) |
| cfg_stop2 | input | 1 | Two stop bits |
| cfg_thresh | input | CNT_W | Queue fill threshold for `sts_rdf` |
| en_rie | input | 1 | Receive interrupt enable |
| en_reie | input | 1 | Receive-error interrupt enable |
| clr_err | input | 1 | Clear strobe for parity and framing flags |
| clr_ovr | input | 1 | Clear strobe for overrun flag |
| clr_brk | input | 1 | Clear strobe for break flag |
| rd_en | input | 1 | Remove oldest queue entry |
| rd_data | output | 8 | Oldest queue entry |
| rd_valid | output | 1 | Queue non-empty |
| fill_cnt | output | CNT_W | Queue occupancy |
| sts_fer | output | 1 | Framing error flag |
| sts_per | output | 1 | Parity error flag |
| sts_ovr | output | 1 | Overrun flag |
| sts_brk | output | 1 | Break flag |
| sts_rdf | output | 1 | Fill threshold reached |
| sts_dr | output | 1 | Queue idle with data below threshold |
| irq_rxd | output | 1 | Receive-data interrupt request |
| irq_err | output | 1 | Receive-error interrupt request |
| irq_bov | output | 1 | Break/overrun interrupt request |

## Verification
The properties assume three things about the inputs: `rd_en` is only pulsed while `rd_valid` is 1, a clear strobe is never raised in the same cycle as a character completes, and `cfg_thresh` stays within 1 to DEPTH. The directed stimulus honours all three. It reads only after checking `rd_valid`, pulses clears only while the line is idle and after the frame has finished, and sets the threshold only to 4 or 16. Configuration inputs change only while the receiver is idle, and each bit is held for exactly OSR baud ticks, so the mid-bit sampling point always lands inside the intended bit.

// File: rtl/srx_pkg.sv
package srx_pkg;

   localparam logic [1:0] PAR_NONE = 2'b00;
   localparam logic [1:0] PAR_EVEN = 2'b01;
   localparam logic [1:0] PAR_ODD  = 2'b10;

   typedef enum logic [2:0] {
      RX_IDLE,
      RX_START,
      RX_DATA,
      RX_PAR,
      RX_STOP,
      RX_STOP2,
      RX_GAP,
      RX_HOLD
   } rx_state_e;

   typedef struct packed {
      logic [7:0] data;
      logic       par;
      logic       stop;
   } rx_char_t;

   function automatic logic par_on(input logic [1:0] mode);
      return (mode == PAR_EVEN) || (mode == PAR_ODD);
   endfunction

   function automatic logic par_fail(input logic [1:0] mode, input rx_char_t c);
      logic x;
      x = (^c.data) ^ c.par;
      case (mode)
         PAR_EVEN: return x;
         PAR_ODD:  return ~x;
         default:  return 1'b0;
      endcase
   endfunction

   function automatic logic is_break(input logic [1:0] mode, input rx_char_t c);
      return (c.data == 8'h00) && !c.stop && (!par_on(mode) || !c.par);
   endfunction

endpackage

// File: rtl/srx_frame.sv
module srx_frame
   import srx_pkg::*;
#(
   parameter int OSR         = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     baud_tick,
   input  logic     rxd,
   input  logic     len8,
   input  logic     par_en,
   input  logic     stop2,
   output logic     done,
   output rx_char_t chr,
   output logic     busy
);

   localparam int          PW     = $clog2(OSR);
   localparam logic [PW-1:0] PH_MID = PW'(OSR / 2 - 1);
   localparam logic [PW-1:0] PH_END = PW'(OSR - 1);

   logic rxs;

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign rxs = rxd;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sq;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sq <= '1;
            else        sq <= (sq << 1) | SYNC_STAGES'(rxd);
         end
         assign rxs = sq[SYNC_STAGES-1];
      end
   endgenerate

   rx_state_e   st;
   logic [PW-1:0] ph;
   logic [2:0]  bitn;
   logic [2:0]  last_bit;

   assign last_bit = len8 ? 3'd7 : 3'd6;
   assign busy     = (st != RX_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= RX_IDLE;
         ph   <= '0;
         bitn <= '0;
         chr  <= '0;
         done <= 1'b0;
      end else begin
         done <= 1'b0;
         if (baud_tick) begin
            case (st)
               RX_IDLE: begin
                  if (!rxs) begin
                     st <= RX_START;
                     ph <= '0;
                  end
               end
               RX_START: begin
                  if (ph == PH_MID) begin
                     ph   <= '0;
                     bitn <= '0;
                     if (!rxs) begin
                        st       <= RX_DATA;
                        chr.data <= '0;
                        chr.par  <= 1'b0;
                     end else begin
                        st <= RX_IDLE;
                     end
                  end else begin
                     ph <= ph + 1'b1;
                  end
               end
               RX_DATA: begin
                  if (ph == PH_END) begin
                     ph             <= '0;
                     chr.data[bitn] <= rxs;
                     if (bitn == last_bit) st <= par_en ? RX_PAR : RX_STOP;
                     else                  bitn <= bitn + 1'b1;
                  end else begin
                     ph <= ph + 1'b1;
                  end
               end
               RX_PAR: begin
                  if (ph == PH_END) begin
                     ph      <= '0;
                     chr.par <= rxs;
                     st      <= RX_STOP;
                  end else begin
                     ph <= ph + 1'b1;
                  end
               end
               RX_STOP: begin
                  if (ph == PH_END) begin
                     ph       <= '0;
                     chr.stop <= rxs;
                     done     <= 1'b1;
                     if (!rxs)       st <= RX_HOLD;
                     else if (stop2) st <= RX_STOP2;
                     else            st <= RX_IDLE;
                  end else begin
                     ph <= ph + 1'b1;
                  end
               end
               RX_STOP2: begin
                  if (ph == PH_END) begin
                     ph <= '0;
                     st <= RX_GAP;
                  end else begin
                     ph <= ph + 1'b1;
                  end
               end
               RX_GAP: begin
                  if (ph == PH_MID) st <= RX_IDLE;
                  else              ph <= ph + 1'b1;
               end
               RX_HOLD: begin
                  if (rxs) st <= RX_IDLE;
               end
               default: st <= RX_IDLE;
            endcase
         end
      end
   end

endmodule

// File: rtl/srx_fifo.sv
module srx_fifo #(
   parameter int DEPTH = 16,
   parameter int W     = 8,
   parameter int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [W-1:0]     wdata,
   input  logic             pop,
   output logic [W-1:0]     rdata,
   output logic             empty,
   output logic             full,
   output logic [CNT_W-1:0] count
);

   localparam int AW = $clog2(DEPTH);

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wptr, rptr;
   logic          do_push, do_pop;

   assign empty   = (count == '0);
   assign full    = (count == CNT_W'(DEPTH));
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign rdata   = mem[rptr];

   always_ff @(posedge clk) begin
      if (do_push) mem[wptr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
      end else begin
         if (do_push) wptr <= wptr + 1'b1;
         if (do_pop)  rptr <= rptr + 1'b1;
         case ({do_push, do_pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

endmodule

// File: rtl/srx_status.sv
module srx_status
   import srx_pkg::*;
#(
   parameter int CNT_W    = 5,
   parameter int DR_TICKS = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             baud_tick,
   input  logic             busy,
   input  logic             done,
   input  rx_char_t         chr,
   input  logic [1:0]       par_mode,
   input  logic [CNT_W-1:0] thresh,
   input  logic [CNT_W-1:0] fill,
   input  logic             full,
   input  logic             pop,
   input  logic             clr_err,
   input  logic             clr_ovr,
   input  logic             clr_brk,
   input  logic             rie,
   input  logic             reie,
   output logic             push,
   output logic             fer,
   output logic             per,
   output logic             ovr,
   output logic             brk,
   output logic             rdf,
   output logic             dr,
   output logic             irq_rxd,
   output logic             irq_err,
   output logic             irq_bov
);

   localparam int TW = $clog2(DR_TICKS + 1);

   logic          brk_char;
   logic [TW-1:0] quiet;

   assign brk_char = is_break(par_mode, chr);
   assign push     = done && !full && !ovr && !brk && !brk_char;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fer <= 1'b0;
         per <= 1'b0;
         ovr <= 1'b0;
         brk <= 1'b0;
      end else begin
         if (done && !chr.stop)             fer <= 1'b1;
         else if (clr_err)                  fer <= 1'b0;
         if (done && par_fail(par_mode, chr)) per <= 1'b1;
         else if (clr_err)                  per <= 1'b0;
         if (done && full)                  ovr <= 1'b1;
         else if (clr_ovr)                  ovr <= 1'b0;
         if (done && brk_char)              brk <= 1'b1;
         else if (clr_brk)                  brk <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          quiet <= '0;
      else if (push || pop || fill == '0)  quiet <= '0;
      else if (baud_tick && !busy && !rdf && quiet != TW'(DR_TICKS))
         quiet <= quiet + 1'b1;
   end

   assign rdf     = (fill >= thresh);
   assign dr      = (quiet == TW'(DR_TICKS)) && (fill != '0);
   assign irq_rxd = rie && (rdf || dr);
   assign irq_err = (rie || reie) && (fer || per);
   assign irq_bov = (rie || reie) && (ovr || brk);

endmodule

// File: rtl/serial_rx_gated.sv
module serial_rx_gated
   import srx_pkg::*;
#(
   parameter int DEPTH       = 16,
   parameter int OSR         = 16,
   parameter int SYNC_STAGES = 2,
   parameter int DR_BITS     = 4,
   localparam int CNT_W      = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             baud_tick,
   input  logic             rxd,
   input  logic             cfg_len8,
   input  logic [1:0]       cfg_par,
   input  logic             cfg_stop2,
   input  logic [CNT_W-1:0] cfg_thresh,
   input  logic             en_rie,
   input  logic             en_reie,
   input  logic             clr_err,
   input  logic             clr_ovr,
   input  logic             clr_brk,
   input  logic             rd_en,
   output logic [7:0]       rd_data,
   output logic             rd_valid,
   output logic [CNT_W-1:0] fill_cnt,
   output logic             sts_fer,
   output logic             sts_per,
   output logic             sts_ovr,
   output logic             sts_brk,
   output logic             sts_rdf,
   output logic             sts_dr,
   output logic             irq_rxd,
   output logic             irq_err,
   output logic             irq_bov
);

   localparam int DR_TICKS = DR_BITS * OSR;

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("DEPTH must be a power of two of at least 2");
      end
      if (OSR < 4 || (OSR & (OSR - 1)) != 0) begin : g_bad_osr
         $error("OSR must be a power of two of at least 4");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must be 0 to 4");
      end
      if (DR_BITS < 1) begin : g_bad_dr
         $error("DR_BITS must be at least 1");
      end
   endgenerate

   logic     done, busy, push, pop, empty, full;
   rx_char_t chr;

   assign pop      = rd_en && !empty;
   assign rd_valid = !empty;

   srx_frame #(.OSR(OSR), .SYNC_STAGES(SYNC_STAGES)) frame_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .baud_tick (baud_tick),
      .rxd       (rxd),
      .len8      (cfg_len8),
      .par_en    (par_on(cfg_par)),
      .stop2     (cfg_stop2),
      .done      (done),
      .chr       (chr),
      .busy      (busy)
   );

   srx_fifo #(.DEPTH(DEPTH), .W(8), .CNT_W(CNT_W)) fifo_i (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (push),
      .wdata (chr.data),
      .pop   (pop),
      .rdata (rd_data),
      .empty (empty),
      .full  (full),
      .count (fill_cnt)
   );

   srx_status #(.CNT_W(CNT_W), .DR_TICKS(DR_TICKS)) status_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .baud_tick (baud_tick),
      .busy      (busy),
      .done      (done),
      .chr       (chr),
      .par_mode  (cfg_par),
      .thresh    (cfg_thresh),
      .fill      (fill_cnt),
      .full      (full),
      .pop       (pop),
      .clr_err   (clr_err),
      .clr_ovr   (clr_ovr),
      .clr_brk   (clr_brk),
      .rie       (en_rie),
      .reie      (en_reie),
      .push      (push),
      .fer       (sts_fer),
      .per       (sts_per),
      .ovr       (sts_ovr),
      .brk       (sts_brk),
      .rdf       (sts_rdf),
      .dr        (sts_dr),
      .irq_rxd   (irq_rxd),
      .irq_err   (irq_err),
      .irq_bov   (irq_bov)
   );

endmodule

// File: rtl/srx_chk.sv
module srx_chk #(
   parameter int DEPTH = 16,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             rd_en,
   input logic             clr_ovr,
   input logic             clr_brk,
   input logic             en_rie,
   input logic             en_reie,
   input logic [CNT_W-1:0] fill_cnt,
   input logic             sts_fer,
   input logic             sts_per,
   input logic             sts_ovr,
   input logic             sts_brk,
   input logic             sts_rdf,
   input logic             sts_dr,
   input logic             irq_rxd,
   input logic             irq_err,
   input logic             irq_bov
);

   // R7
   fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fill_cnt <= CNT_W'(DEPTH));

   // R4
   ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_ovr && !clr_ovr) |=> sts_ovr);

   // R4
   ovr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sts_ovr |=> (fill_cnt <= $past(fill_cnt)));

   // R6
   brk_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_brk && !clr_brk) |=> sts_brk);

   // R6
   brk_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sts_brk |=> (fill_cnt <= $past(fill_cnt)));

   // R7
   full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_en && fill_cnt == CNT_W'(DEPTH)) |=> (fill_cnt == CNT_W'(DEPTH)));

   // R9
   irq_rx_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_rxd |-> (en_rie && (sts_rdf || sts_dr)));

   // R10
   irq_err_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_err |-> ((en_rie || en_reie) && (sts_fer || sts_per)));

   // R11
   irq_bov_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_bov |-> ((en_rie || en_reie) && (sts_ovr || sts_brk)));

   // R9
   dr_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sts_dr |-> (fill_cnt != '0));

endmodule

bind serial_rx_gated srx_chk #(.DEPTH(DEPTH)) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .rd_en    (rd_en),
   .clr_ovr  (clr_ovr),
   .clr_brk  (clr_brk),
   .en_rie   (en_rie),
   .en_reie  (en_reie),
   .fill_cnt (fill_cnt),
   .sts_fer  (sts_fer),
   .sts_per  (sts_per),
   .sts_ovr  (sts_ovr),
   .sts_brk  (sts_brk),
   .sts_rdf  (sts_rdf),
   .sts_dr   (sts_dr),
   .irq_rxd  (irq_rxd),
   .irq_err  (irq_err),
   .irq_bov  (irq_bov)
);

// File: tb/serial_rx_gated_tb_top.sv
`timescale 1ns/1ps
module serial_rx_gated_tb_top;

   localparam int BITCLK = 64;  // 16 ticks, tick every 4 clocks

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       baud_tick;
   logic       rxd = 1'b1;
   logic       cfg_len8 = 1'b1;
   logic [1:0] cfg_par = 2'b00;
   logic       cfg_stop2 = 1'b0;
   logic [4:0] cfg_thresh = 5'd4;
   logic       en_rie = 1'b1;
   logic       en_reie = 1'b1;
   logic       clr_err = 1'b0;
   logic       clr_ovr = 1'b0;
   logic       clr_brk = 1'b0;
   logic       rd_en = 1'b0;
   logic [7:0] rd_data;
   logic       rd_valid;
   logic [4:0] fill_cnt;
   logic       sts_fer, sts_per, sts_ovr, sts_brk, sts_rdf, sts_dr;
   logic       irq_rxd, irq_err, irq_bov;

   logic [1:0] tdiv = 2'd0;
   int         nchk = 0;
   int         nerr = 0;
   bit         finished = 1'b0;

   always #2 clk = ~clk;
   always @(posedge clk) tdiv <= tdiv + 2'd1;
   assign baud_tick = (tdiv == 2'd3);

   serial_rx_gated dut_i (
      .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .rxd(rxd),
      .cfg_len8(cfg_len8), .cfg_par(cfg_par), .cfg_stop2(cfg_stop2),
      .cfg_thresh(cfg_thresh), .en_rie(en_rie), .en_reie(en_reie),
      .clr_err(clr_err), .clr_ovr(clr_ovr), .clr_brk(clr_brk),
      .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid),
      .fill_cnt(fill_cnt), .sts_fer(sts_fer), .sts_per(sts_per),
      .sts_ovr(sts_ovr), .sts_brk(sts_brk), .sts_rdf(sts_rdf),
      .sts_dr(sts_dr), .irq_rxd(irq_rxd), .irq_err(irq_err),
      .irq_bov(irq_bov)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      nchk++;
      if (act != exp) begin
         nerr++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic drive_bit(input logic v);
      rxd = v;
      repeat (BITCLK) @(negedge clk);
   endtask

   task automatic send(input logic [7:0] d, input int nbits, input logic pen,
                       input logic pval, input logic s1, input logic s2en,
                       input logic s2);
      drive_bit(1'b0);
      for (int i = 0; i < nbits; i++) drive_bit(d[i]);
      if (pen) drive_bit(pval);
      drive_bit(s1);
      if (s2en) drive_bit(s2);
      drive_bit(1'b1);
   endtask

   task automatic send8(input logic [7:0] d);
      send(d, 8, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
   endtask

   task automatic pulse(ref logic s);
      s = 1'b1;
      @(negedge clk);
      s = 1'b0;
      @(negedge clk);
   endtask

   task automatic pop_chk(input string req, input logic [7:0] exp);
      chk(req, "rd_valid before read", int'(rd_valid), 1);
      chk(req, "rd_data", int'(rd_data), int'(exp));
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      @(negedge clk);
   endtask

   task automatic t_reset;
      chk("R12", "rd_valid", int'(rd_valid), 0);
      chk("R12", "fill_cnt", int'(fill_cnt), 0);
      chk("R12", "flags", int'({sts_fer, sts_per, sts_ovr, sts_brk, sts_rdf, sts_dr}), 0);
      chk("R12", "irqs", int'({irq_rxd, irq_err, irq_bov}), 0);
   endtask

   task automatic t_basic;
      send8(8'hA5);
      chk("R2", "fill after one char", int'(fill_cnt), 1);
      chk("R2", "lsb-first data", int'(rd_data), 'hA5);
      chk("R2", "no error flags", int'({sts_fer, sts_per}), 0);
      send8(8'h3C);
      chk("R7", "fill after two", int'(fill_cnt), 2);
      pop_chk("R7", 8'hA5);
      pop_chk("R7", 8'h3C);
      chk("R7", "empty after reads", int'(rd_valid), 0);
   endtask

   task automatic t_glitch;
      rxd = 1'b0;
      repeat (16) @(negedge clk);   // 4 ticks low
      rxd = 1'b1;
      repeat (3 * BITCLK) @(negedge clk);
      chk("R1", "glitch gives no char", int'(fill_cnt), 0);
      chk("R1", "glitch sets no flag", int'({sts_fer, sts_brk}), 0);
   endtask

   task automatic t_parity;
      cfg_len8 = 1'b0;
      cfg_par  = 2'b01;             // even
      send(8'h6B, 7, 1'b1, ^(7'h6B), 1'b1, 1'b0, 1'b1);
      chk("R3", "even parity ok", int'(sts_per), 0);
      pop_chk("R2", 8'h6B);         // 7-bit, bit7 reads 0
      cfg_par = 2'b10;              // odd, send even value -> mismatch
      send(8'h35, 7, 1'b1, ^(7'h35), 1'b1, 1'b0, 1'b1);
      chk("R3", "odd parity mismatch flagged", int'(sts_per), 1);
      chk("R3", "char stored despite parity error", int'(fill_cnt), 1);
      chk("R10", "irq_err on parity", int'(irq_err), 1);
      pop_chk("R3", 8'h35);
      pulse(clr_err);
      chk("R10", "clr_err clears per", int'(sts_per), 0);
      chk("R10", "irq_err drops", int'(irq_err), 0);
      cfg_len8 = 1'b1;
      cfg_par  = 2'b00;
   endtask

   task automatic t_frame;
      send(8'h81, 8, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
      chk("R5", "framing flag", int'(sts_fer), 1);
      chk("R5", "char stored with framing error", int'(fill_cnt), 1);
      chk("R5", "no break on nonzero data", int'(sts_brk), 0);
      pop_chk("R5", 8'h81);
      pulse(clr_err);
      chk("R10", "clr_err clears fer", int'(sts_fer), 0);
      cfg_stop2 = 1'b1;
      send(8'h42, 8, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
      chk("R5", "second stop bit unchecked", int'(sts_fer), 0);
      chk("R5", "second stop not a start", int'(fill_cnt), 1);
      pop_chk("R5", 8'h42);
      cfg_stop2 = 1'b0;
   endtask

   task automatic t_break;
      send(8'h00, 8, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
      chk("R6", "break flag", int'(sts_brk), 1);
      chk("R6", "break also framing", int'(sts_fer), 1);
      chk("R6", "break char not stored", int'(fill_cnt), 0);
      chk("R11", "irq_bov on break", int'(irq_bov), 1);
      send8(8'h55);
      chk("R6", "write blocked while break set", int'(fill_cnt), 0);
      pulse(clr_brk);
      pulse(clr_err);
      chk("R11", "irq_bov drops", int'(irq_bov), 0);
      send8(8'h55);
      chk("R6", "write resumes after clear", int'(fill_cnt), 1);
      pop_chk("R6", 8'h55);
   endtask

   task automatic t_overrun;
      cfg_thresh = 5'd16;
      for (int i = 0; i < 16; i++) begin
         send8(8'(i + 1));
         if (i == 14) chk("R8", "rdf below threshold", int'(sts_rdf), 0);
      end
      chk("R8", "rdf at threshold", int'(sts_rdf), 1);
      chk("R9", "irq_rxd on rdf", int'(irq_rxd), 1);
      chk("R7", "queue full", int'(fill_cnt), 16);
      send8(8'hEE);
      chk("R4", "overrun flag", int'(sts_ovr), 1);
      chk("R4", "fill unchanged", int'(fill_cnt), 16);
      chk("R11", "irq_bov on overrun", int'(irq_bov), 1);
      for (int i = 0; i < 16; i++) pop_chk("R4", 8'(i + 1));
      send8(8'h11);
      chk("R4", "write blocked while overrun", int'(fill_cnt), 0);
      chk("R4", "overrun sticky", int'(sts_ovr), 1);
      pulse(clr_ovr);
      send8(8'h22);
      chk("R4", "write resumes after clear", int'(fill_cnt), 1);
      pop_chk("R4", 8'h22);
      cfg_thresh = 5'd4;
   endtask

   task automatic t_ready;
      send8(8'h99);
      chk("R9", "dr not yet", int'(sts_dr), 0);
      chk("R9", "irq_rxd not yet", int'(irq_rxd), 0);
      repeat (300) @(negedge clk);
      chk("R9", "dr after quiet time", int'(sts_dr), 1);
      chk("R9", "irq_rxd on dr", int'(irq_rxd), 1);
      en_rie = 1'b0;
      @(negedge clk);
      chk("R9", "irq_rxd masked", int'(irq_rxd), 0);
      en_rie = 1'b1;
      pop_chk("R9", 8'h99);
      chk("R9", "dr clears when empty", int'(sts_dr), 0);
   endtask

   task automatic t_enables;
      en_rie  = 1'b0;
      en_reie = 1'b0;
      send(8'h00, 8, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
      chk("R11", "break flag set", int'(sts_brk), 1);
      chk("R11", "irq_bov masked", int'(irq_bov), 0);
      chk("R10", "irq_err masked", int'(irq_err), 0);
      en_reie = 1'b1;
      @(negedge clk);
      chk("R11", "irq_bov via reie", int'(irq_bov), 1);
      chk("R10", "irq_err via reie", int'(irq_err), 1);
      chk("R9", "irq_rxd needs rie", int'(irq_rxd), 0);
      pulse(clr_brk);
      pulse(clr_err);
      en_rie = 1'b1;
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      t_reset();
      t_basic();
      t_glitch();
      t_parity();
      t_frame();
      t_break();
      t_overrun();
      t_ready();
      t_enables();
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         nchk++;
         nerr++;
         $display("FAIL watchdog: actual hung expected done");
         $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
         $finish;
      end
   end

endmodule